// File: doc/BRIEF.md
# Table-Encoded Clock-Enable Divider

This block divides a fast clock down to a one-cycle enable pulse. It counts pulses from a chosen source enable and emits one output pulse each time the count reaches the division ratio. The output is an enable, not a clock, so odd ratios work without any duty-cycle correction. Logic downstream runs on the fast clock and acts only in cycles where the pulse is high.

The ratio comes from a 3-bit select code. A build-time mode parameter chooses one of four decode tables. Two of these tables give the same ratio for the two lowest codes. A gate input stops the divider. A source-select input picks the counted source: either an internal enable that is high on every second clock, or an external enable input. A new select code takes effect only at a period boundary, so a running period is never cut short.

Top module: `clkdiv_table`

## Requirements
- R1: After the synchronous reset, `tick_o` is low and the divider count is zero.
- R2: With mode `DIV_MODE_X4`, the ratio is 4*(sel+1), giving 4, 8, 12 and so on up to 32 for sel = 0..7.
- R3: With mode `DIV_MODE_X2`, the ratio is 2*(sel+1), giving 2 to 16.
- R4: With mode `DIV_MODE_X2_FLOOR4`, sel 0 and sel 1 both give 4, and sel 2..7 give 2*(sel+1), which is 6 to 16.
- R5: With mode `DIV_MODE_X1_FLOOR2`, sel 0 and sel 1 both give 2, and sel 2..7 give sel+1, which is 3 to 8.
- R6: While `gate_i` is low, `tick_o` stays low and the count is held at zero. Suppose `gate_i` rises before a clock edge k and the source enable is constantly high. The first pulse is then visible after edge k+N-1, which is N edges after the rise (N is the ratio).
- R7: With `src_sel_i` = 0, the counted source is an internal enable that is high on every second clock. Output pulses are therefore 2*N clocks apart.
- R8: With `src_sel_i` = 1, only cycles with `alt_en_i` high advance the count. If `alt_en_i` stays low, no pulse appears.
- R9: A change of `sel_i` while the gate is on takes effect only after the next output pulse. The period already running completes at the old ratio.
- R10: `tick_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_i | input | 1 | Synchronous active-high reset |
| gate_i | input | 1 | 1 = run the divider, 0 = hold the count at zero with no output |
| src_sel_i | input | 1 | 0 = internal half-rate enable, 1 = `alt_en_i` |
| alt_en_i | input | 1 | External source enable |
| sel_i | input | SEL_W | Ratio select code |
| tick_o | output | 1 | One-cycle divided enable pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the output never stays high for two cycles in a row;
- the output stays quiet and the count clears while the gate is off;
- the count stays below the active ratio;
- the active ratio stays fixed between pulses;
- every pulse follows a cycle with a source enable;
- the internal half-rate enable alternates.

Other behaviour can only be shown by the bench's scenarios. This covers the exact ratio of every code in all four tables, including the aliased low codes. It also covers the doubled period on the internal source, counting only the external enable pulses, the latency from gate-on to the first pulse, and a mid-period select change completing at the old ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        DIV_MODE_X4        = 2'd0,
        DIV_MODE_X2        = 2'd1,
        DIV_MODE_X2_FLOOR4 = 2'd2,
        DIV_MODE_X1_FLOOR2 = 2'd3
    } div_mode_e;

    typedef struct packed {
        logic load;   // take a new ratio this cycle
        logic term;   // terminal count reached on a source enable
    } div_ctl_t;

    // Division ratio selected by a code under a given table
    function automatic int unsigned ratio_of(div_mode_e mode, int unsigned code);
        int unsigned r;
        case (mode)
            DIV_MODE_X4:        r = 4 * (code + 1);
            DIV_MODE_X2:        r = 2 * (code + 1);
            DIV_MODE_X2_FLOOR4: r = (code < 2) ? 4 : 2 * (code + 1);
            default:            r = (code < 2) ? 2 : code + 1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_src.sv
module clkdiv_src (
    input  logic clk_i,
    input  logic rst_i,
    input  logic src_sel_i,
    input  logic alt_en_i,
    output logic src_en_o
);
    logic phase_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) phase_q <= 1'b0;
        else       phase_q <= ~phase_q;
    end

    assign src_en_o = src_sel_i ? alt_en_i : phase_q;

    AST_HALF_ALTERNATE: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_q |=> !phase_q); // R7

endmodule

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio
    import clkdiv_pkg::*;
#(
    parameter div_mode_e MODE    = DIV_MODE_X4,
    parameter int        SEL_W   = 3,
    parameter int        RATIO_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [RATIO_W-1:0] ratio_o
);
    logic [RATIO_W-1:0] dec;
    logic [RATIO_W-1:0] ratio_q;

    always_comb begin
        dec = RATIO_W'(ratio_of(MODE, int'(sel_i)));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || load_i) ratio_q <= dec;
    end

    assign ratio_o = ratio_q;

    AST_RATIO_MIN: assert property (@(posedge clk_i) disable iff (rst_i)
        ratio_q >= RATIO_W'(2)); // R10

endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               gate_i,
    input  logic               src_en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output div_ctl_t           ctl_o,
    output logic               tick_o
);
    logic [RATIO_W-1:0] cnt_q;
    logic               tick_q;
    div_ctl_t           ctl;

    always_comb begin
        ctl.term = gate_i && src_en_i && (cnt_q == ratio_i - RATIO_W'(1));
        ctl.load = !gate_i || ctl.term;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !gate_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= ctl.term;
            if (ctl.term)      cnt_q <= '0;
            else if (src_en_i) cnt_q <= cnt_q + RATIO_W'(1);
        end
    end

    assign ctl_o  = ctl;
    assign tick_o = tick_q;

    AST_GATE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !gate_i |=> !tick_q); // R6
    AST_GATE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        !gate_i |=> (cnt_q == '0)); // R6
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < ratio_i); // R9
    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_q |=> !tick_q); // R10
    AST_TICK_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_q |-> $past(src_en_i)); // R8

endmodule

// File: rtl/clkdiv_table.sv
module clkdiv_table
    import clkdiv_pkg::*;
#(
    parameter div_mode_e MODE  = DIV_MODE_X4,
    parameter int        SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             gate_i,
    input  logic             src_sel_i,
    input  logic             alt_en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int MAX_RATIO = 4 * (2 ** SEL_W);
    localparam int RATIO_W   = $clog2(MAX_RATIO) + 1;

    logic               src_en;
    logic [RATIO_W-1:0] ratio;
    div_ctl_t           ctl;

    clkdiv_src u_src (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .src_sel_i (src_sel_i),
        .alt_en_i  (alt_en_i),
        .src_en_o  (src_en)
    );

    clkdiv_ratio #(.MODE(MODE), .SEL_W(SEL_W), .RATIO_W(RATIO_W)) u_ratio (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (ctl.load),
        .sel_i   (sel_i),
        .ratio_o (ratio)
    );

    clkdiv_count #(.RATIO_W(RATIO_W)) u_count (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .gate_i   (gate_i),
        .src_en_i (src_en),
        .ratio_i  (ratio),
        .ctl_o    (ctl),
        .tick_o   (tick_o)
    );

    AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_i && !ctl.term) |=> $stable(ratio)); // R9

endmodule

// File: tb/test_clkdiv_table.sv
module test_clkdiv_table;
    import clkdiv_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_sel = 1'b1;
    logic       alt_en;
    int         alt_style = 0;   // 0: constant high, 1: every third clock, 2: low
    logic [3:0] gate = '0;
    logic [2:0] sel [4];
    logic [3:0] tick;
    int         tests = 0;
    int         fails = 0;
    int         cyc = 0;
    int         alt_cnt = 0;

    always #2 clk = ~clk;   // 250 MHz

    clkdiv_table #(.MODE(DIV_MODE_X4)) i_clkdiv_table (
        .clk_i(clk), .rst_i(rst), .gate_i(gate[0]), .src_sel_i(src_sel),
        .alt_en_i(alt_en), .sel_i(sel[0]), .tick_o(tick[0]));
    clkdiv_table #(.MODE(DIV_MODE_X2)) i_clkdiv_table_b (
        .clk_i(clk), .rst_i(rst), .gate_i(gate[1]), .src_sel_i(src_sel),
        .alt_en_i(alt_en), .sel_i(sel[1]), .tick_o(tick[1]));
    clkdiv_table #(.MODE(DIV_MODE_X2_FLOOR4)) i_clkdiv_table_c (
        .clk_i(clk), .rst_i(rst), .gate_i(gate[2]), .src_sel_i(src_sel),
        .alt_en_i(alt_en), .sel_i(sel[2]), .tick_o(tick[2]));
    clkdiv_table #(.MODE(DIV_MODE_X1_FLOOR2)) i_clkdiv_table_d (
        .clk_i(clk), .rst_i(rst), .gate_i(gate[3]), .src_sel_i(src_sel),
        .alt_en_i(alt_en), .sel_i(sel[3]), .tick_o(tick[3]));

    always_comb begin
        case (alt_style)
            0:       alt_en = 1'b1;
            1:       alt_en = (alt_cnt == 2);
            default: alt_en = 1'b0;
        endcase
    end

    always @(negedge clk) alt_cnt <= (alt_cnt == 2) ? 0 : alt_cnt + 1;

    // Vector table: {instance[1:0], sel[2:0], expected ratio[5:0]}
    localparam logic [10:0] VEC [32] = '{
        {2'd0,3'd0,6'd4},  {2'd0,3'd1,6'd8},  {2'd0,3'd2,6'd12}, {2'd0,3'd3,6'd16},
        {2'd0,3'd4,6'd20}, {2'd0,3'd5,6'd24}, {2'd0,3'd6,6'd28}, {2'd0,3'd7,6'd32},
        {2'd1,3'd0,6'd2},  {2'd1,3'd1,6'd4},  {2'd1,3'd2,6'd6},  {2'd1,3'd3,6'd8},
        {2'd1,3'd4,6'd10}, {2'd1,3'd5,6'd12}, {2'd1,3'd6,6'd14}, {2'd1,3'd7,6'd16},
        {2'd2,3'd0,6'd4},  {2'd2,3'd1,6'd4},  {2'd2,3'd2,6'd6},  {2'd2,3'd3,6'd8},
        {2'd2,3'd4,6'd10}, {2'd2,3'd5,6'd12}, {2'd2,3'd6,6'd14}, {2'd2,3'd7,6'd16},
        {2'd3,3'd0,6'd2},  {2'd3,3'd1,6'd2},  {2'd3,3'd2,6'd3},  {2'd3,3'd3,6'd4},
        {2'd3,3'd4,6'd5},  {2'd3,3'd5,6'd6},  {2'd3,3'd6,6'd7},  {2'd3,3'd7,6'd8}
    };

    function automatic string mode_req(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Edges until tick of instance idx is seen high (or -1 after limit)
    task automatic measure(input int idx, input int limit, output int n);
        n = -1;
        for (int k = 1; k <= limit; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick[idx]) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic count_ticks(input int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tick != 4'b0) hits++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int hits;
        for (int i = 0; i < 4; i++) sel[i] = 3'd0;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, nothing pulses
        check(tick == 4'b0, "R1", int'(tick), 0);

        // Table walk, alternate source held high: latency and period equal the ratio
        for (int v = 0; v < 32; v++) begin
            int m;
            int r;
            m = int'(VEC[v][10:9]);
            r = int'(VEC[v][5:0]);
            gate[m]   = 1'b0;
            sel[m]    = VEC[v][8:6];
            src_sel   = 1'b1;
            alt_style = 0;
            cycles(2);
            gate[m] = 1'b1;
            measure(m, 200, n);
            check(n == r, mode_req(m), n, r);
            measure(m, 200, n);
            check(n == r, mode_req(m), n, r);
            gate[m] = 1'b0;
            @(negedge clk);
        end

        // R6: gate off keeps output low, then first pulse after exactly N edges
        gate = 4'b0;
        sel[1] = 3'd3;
        count_ticks(60, hits);
        check(hits == 0, "R6", hits, 0);
        gate[1] = 1'b1;
        measure(1, 200, n);
        check(n == 8, "R6", n, 8);
        gate[1] = 1'b0;
        @(negedge clk);

        // R10: ratio 2, tick low in the cycle after a pulse
        sel[3]  = 3'd0;
        gate[3] = 1'b1;
        measure(3, 50, n);
        @(posedge clk);
        @(negedge clk);
        check(tick[3] == 1'b0, "R10", int'(tick[3]), 0);
        gate[3] = 1'b0;
        @(negedge clk);

        // R7: internal half-rate source doubles the period
        src_sel = 1'b0;
        sel[0]  = 3'd0;
        gate[0] = 1'b1;
        measure(0, 200, n);
        measure(0, 200, n);
        check(n == 8, "R7", n, 8);
        gate[0] = 1'b0;
        sel[0]  = 3'd2;
        @(negedge clk);
        gate[0] = 1'b1;
        measure(0, 200, n);
        measure(0, 200, n);
        check(n == 24, "R7", n, 24);
        gate[0] = 1'b0;
        @(negedge clk);

        // R8: only external enable pulses (every third clock) are counted
        src_sel   = 1'b1;
        alt_style = 1;
        sel[3]    = 3'd3;
        gate[3]   = 1'b1;
        measure(3, 200, n);
        measure(3, 200, n);
        check(n == 12, "R8", n, 12);
        alt_style = 2;
        count_ticks(100, hits);
        check(hits == 0, "R8", hits, 0);
        gate[3] = 1'b0;
        alt_style = 0;
        @(negedge clk);

        // R9: select change mid-period finishes at old ratio
        sel[1]  = 3'd7;
        gate[1] = 1'b1;
        measure(1, 200, n);
        cycles(3);
        sel[1] = 3'd0;
        measure(1, 200, n);
        check(n == 13, "R9", n, 13);   // 16 minus the 3 cycles already waited
        measure(1, 200, n);
        check(n == 2, "R9", n, 2);
        gate[1] = 1'b0;

        // R1: reset again mid-run clears output
        gate = 4'b1111;
        cycles(5);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        gate = 4'b0;
        check(tick == 4'b0, "R1", int'(tick), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule